// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block sits between a processor-side request port and a small group of emulated single-function PCI devices. It handles configuration traffic that arrives by two routes and resolves both into one target: a bus number, a device number, a function number and a byte offset within a 256-byte header. The first route is the two-port method, where software writes a 32-bit selector into an address latch and then accesses a data port. The second route is a memory-mapped window, where the selector is taken from the bus address itself.

Both routes share one decode path and one set of header stores, one store per device slot. When the decoded target is absent, reads return all ones and writes are dropped. A per-slot presence mask tells the block which slots hold a device. Requests arrive on a valid/ready port that accepts one request per cycle. Each request carries a kind, an address, a byte count and write data. Write data and read data are byte-packed from bit 0, so byte k of the transfer sits at bits 8k+7:8k.

Top module: `cfgdec_top`

## Requirements
- R1: After reset the address latch reads as 0, and `rsp_valid` is low.
- R2: The address latch is selected by kind 0. On a write, byte k of the transfer goes to latch byte (addr[1:0]+k), for k below the effective length. Lanes that would fall past latch byte 3 are dropped. A read returns the same lanes, and lanes past byte 3 read 0. Latch bits 1:0 always read 0.
- R3: The data port is selected by kind 1. Its configuration address is the latch with bits 1:0 replaced by addr[1:0]. That address decodes as bus in bits 23:16, device in bits 15:11, function in bits 10:8 and header offset in bits 7:0. Byte k of the transfer maps to header byte (offset+k).
- R4: The effective length is min(`req_len`, 4). Read data bytes at or above the effective length are 0, and a length of 0 touches nothing.
- R5: A target is present only when all of these hold: the kind is 1 or 2, the bus equals `BUS_NUM`, the function is 0, the device is below `NUM_DEV`, and the device's bit of `dev_present` is set. Kind 3 is never present.
- R6: A read from an absent target returns 0xFF in every accessed byte. A write to an absent target changes no stored header byte.
- R7: The memory-mapped window is selected by kind 2. Its configuration address is `req_addr - WIN_BASE`, decoded with the field layout of R3. Accesses through the window, and accesses through the data port, leave the address latch unchanged.
- R8: Header byte addresses wrap modulo the header size (256), so the byte after offset 0xFF is offset 0x00.
- R9: `req_ready` is high, so a request is accepted whenever `req_valid` is high. `rsp_valid` is high exactly in the cycle after an accepted read, and it carries that read's data. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_kind | input | 2 | 0 address latch, 1 data port, 2 window, 3 unused |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Port byte offset in bits 1:0, or full bus address for the window |
| req_len | input | 4 | Byte count, limited to 4 |
| req_wdata | input | 32 | Write bytes, packed from bit 0 |
| dev_present | input | NUM_DEV | Slot holds a device |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read bytes, packed from bit 0 |

## Verification
Every read result appears on `rsp_data` exactly one clock edge after the request is accepted. The bench therefore drives each request just after a falling edge and compares the response at the next falling edge. By that point exactly one rising edge has registered it. Writes to the latch or to a header take effect on that same rising edge, so the request that follows already sees the new state. The bench keeps one request in flight at a time, which means each comparison belongs to exactly one request. The bench's behavioural model is updated when each request is issued, in the same order as the requests.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_DATA = 2'd1,
        K_WIN  = 2'd2,
        K_NONE = 2'd3
    } kind_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [7:0] ofs;
    } tgt_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } rsp_t;
endpackage

// File: rtl/cfgdec_addr_latch.sv
module cfgdec_addr_latch
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0] wbytes,
    output logic [WORD_W-1:0] latch_q
);
    logic [WORD_W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i]) latch_d[i*BYTE_W +: BYTE_W] = wbytes[i*BYTE_W +: BYTE_W];
            end
        end
        latch_d[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end
endmodule

// File: rtl/cfgdec_route.sv
module cfgdec_route
    import cfgdec_pkg::*;
#(
    parameter int          NUM_DEV   = 4,
    parameter int          HDR_BYTES = 256,
    parameter int          BUS_NUM   = 0,
    parameter logic [31:0] WIN_BASE  = 32'h3000_0000,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int OFS_W = $clog2(HDR_BYTES)
) (
    input  kind_e              kind,
    input  logic [31:0]        addr,
    input  logic [23:2]        latch_lo,
    input  logic [NUM_DEV-1:0] dev_present,
    output logic [DEV_W-1:0]   dev_idx,
    output logic [OFS_W-1:0]   ofs,
    output logic               present
);
    logic [23:0] cfg_lo;
    tgt_t        tgt;
    logic        slot_hit;

    always_comb begin
        if (kind == K_WIN) cfg_lo = 24'(addr - WIN_BASE);
        else               cfg_lo = {latch_lo, addr[1:0]};
        tgt = tgt_t'(cfg_lo);

        slot_hit = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (int'(tgt.dev) == i) slot_hit = dev_present[i];
        end

        present = (kind == K_DATA || kind == K_WIN)
               && (tgt.bus == 8'(BUS_NUM))
               && (tgt.fn == 3'd0)
               && slot_hit;
        dev_idx = DEV_W'(tgt.dev);
        ofs     = OFS_W'(tgt.ofs);
    end
endmodule

// File: rtl/cfgdec_hdr_store.sv
module cfgdec_hdr_store
    import cfgdec_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int HDR_BYTES = 256,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int OFS_W = $clog2(HDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic [OFS_W-1:0]  base_ofs,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0] wbytes,
    output logic [WORD_W-1:0] rbytes
);
    logic [NUM_DEV-1:0][WORD_W-1:0] rd_dev;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
        logic [BYTE_W-1:0] mem [HDR_BYTES];
        logic [WORD_W-1:0] rd_g;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < HDR_BYTES; k++) mem[k] <= '0;
            end else if (wr_en && dev_sel == DEV_W'(g)) begin
                for (int i = 0; i < LANES; i++) begin
                    if (lane_we[i]) mem[base_ofs + OFS_W'(i)] <= wbytes[i*BYTE_W +: BYTE_W];
                end
            end
        end

        always_comb begin
            for (int i = 0; i < LANES; i++) rd_g[i*BYTE_W +: BYTE_W] = mem[base_ofs + OFS_W'(i)];
        end

        assign rd_dev[g] = rd_g;
    end

    assign rbytes = rd_dev[dev_sel];
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter int          NUM_DEV   = 4,
    parameter int          HDR_BYTES = 256,
    parameter int          BUS_NUM   = 0,
    parameter logic [31:0] WIN_BASE  = 32'h3000_0000,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int OFS_W = $clog2(HDR_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic               req_write,
    input  logic [31:0]        req_addr,
    input  logic [3:0]         req_len,
    input  logic [31:0]        req_wdata,
    input  logic [NUM_DEV-1:0] dev_present,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data
);
    kind_e             kind;
    logic [2:0]        eff_len;
    logic [LANES-1:0]  lane_act;
    logic [WORD_W-1:0] byte_mask;
    logic [1:0]        port_off;
    logic              lat_we;
    logic [LANES-1:0]  lat_lane;
    logic [WORD_W-1:0] lat_wbytes;
    logic [WORD_W-1:0] lat_rd;
    logic [WORD_W-1:0] latch_q;
    logic [DEV_W-1:0]  dev_idx;
    logic [OFS_W-1:0]  hdr_ofs;
    logic              present;
    logic              hdr_we;
    logic [WORD_W-1:0] hdr_rbytes;
    logic [WORD_W-1:0] hdr_rd;
    rsp_t              st_d, st_q;

    assign kind      = kind_e'(req_kind);
    assign req_ready = 1'b1;

    always_comb begin
        eff_len  = (req_len > 4'd4) ? 3'd4 : req_len[2:0];
        for (int i = 0; i < LANES; i++) begin
            lane_act[i]                   = (3'(i) < eff_len);
            byte_mask[i*BYTE_W +: BYTE_W] = {BYTE_W{lane_act[i]}};
        end
        port_off   = req_addr[1:0];

        lat_we     = req_valid && req_write && (kind == K_ADDR);
        lat_lane   = lane_act << port_off;
        lat_wbytes = req_wdata << {port_off, 3'b000};
        lat_rd     = (latch_q >> {port_off, 3'b000}) & byte_mask;

        hdr_we     = req_valid && req_write && present;
        hdr_rd     = (present ? hdr_rbytes : {WORD_W{1'b1}}) & byte_mask;

        st_d.vld   = req_valid && !req_write;
        st_d.data  = '0;
        if (req_valid && !req_write) st_d.data = (kind == K_ADDR) ? lat_rd : hdr_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_data  = st_q.data;

    cfgdec_addr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lat_we),
        .lane_we (lat_lane),
        .wbytes  (lat_wbytes),
        .latch_q (latch_q)
    );

    cfgdec_route #(
        .NUM_DEV   (NUM_DEV),
        .HDR_BYTES (HDR_BYTES),
        .BUS_NUM   (BUS_NUM),
        .WIN_BASE  (WIN_BASE)
    ) u_route (
        .kind        (kind),
        .addr        (req_addr),
        .latch_lo    (latch_q[23:2]),
        .dev_present (dev_present),
        .dev_idx     (dev_idx),
        .ofs         (hdr_ofs),
        .present     (present)
    );

    cfgdec_hdr_store #(
        .NUM_DEV   (NUM_DEV),
        .HDR_BYTES (HDR_BYTES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hdr_we),
        .dev_sel  (dev_idx),
        .base_ofs (hdr_ofs),
        .lane_we  (lane_act),
        .wbytes   (req_wdata),
        .rbytes   (hdr_rbytes)
    );
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_kind,
    input logic        req_write,
    input logic [3:0]  req_len,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic [31:0] latch_q
);
    a_r9_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    a_r9_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_kind == 2'd0) |=> $stable(latch_q));

    a_r4_single_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_len == 4'd1) |=> (rsp_data[31:8] == 24'd0));
endmodule

bind cfgdec_top cfgdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_write (req_write),
    .req_len   (req_len),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .latch_q   (latch_q)
);

// File: tb/sim_cfgdec_top.sv
`timescale 1ns/1ps
module sim_cfgdec_top;
    localparam logic [31:0] WIN = 32'h3000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  dev_present = 4'b1011;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    logic [31:0] m_latch = '0;
    logic [7:0]  m_hdr [4][256];

    always #5 clk = ~clk;

    cfgdec_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .dev_present(dev_present),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] sel(int bus, int dev, int fn, int ofs);
        return {8'h80, 8'(bus), 5'(dev), 3'(fn), 8'(ofs & 8'hFC)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input int k, input bit wr, input logic [31:0] a, input int len,
                         input logic [31:0] wd, output bit er, output logic [31:0] ed);
        int n, bus, dev, fn, off;
        bit pres;
        logic [31:0] ca;
        n  = (len > 4) ? 4 : len;
        er = !wr;
        ed = '0;
        if (k == 0) begin
            for (int i = 0; i < n; i++) begin
                int p = int'(a[1:0]) + i;
                if (p < 4) begin
                    if (wr) m_latch[p*8 +: 8] = wd[i*8 +: 8];
                    else    ed[i*8 +: 8] = m_latch[p*8 +: 8];
                end
            end
            m_latch[1:0] = 2'b00;
        end else begin
            ca   = (k == 2) ? (a - WIN) : {m_latch[31:2], a[1:0]};
            bus  = int'(ca[23:16]);
            dev  = int'(ca[15:11]);
            fn   = int'(ca[10:8]);
            off  = int'(ca[7:0]);
            pres = (k == 1 || k == 2) && bus == 0 && fn == 0 && dev < 4 && dev_present[dev];
            for (int i = 0; i < n; i++) begin
                int o = (off + i) % 256;
                if (wr) begin
                    if (pres) m_hdr[dev][o] = wd[i*8 +: 8];
                end else begin
                    ed[i*8 +: 8] = pres ? m_hdr[dev][o] : 8'hFF;
                end
            end
        end
    endtask

    task automatic access(input int k, input bit wr, input logic [31:0] a, input int len,
                          input logic [31:0] wd, input string tag);
        bit          er;
        logic [31:0] ed;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(k);
        req_write = wr;
        req_addr  = a;
        req_len   = 4'(len);
        req_wdata = wd;
        model(k, wr, a, len, wd, er, ed);
        check("R9", "req_ready", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "rsp_valid", {31'd0, rsp_valid}, {31'd0, er});
        if (er) check(tag, "rsp_data", rsp_data, ed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 4; d++)
            for (int b = 0; b < 256; b++) m_hdr[d][b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        access(0, 0, 32'h0, 4, 0, "R1");

        // R2: latch lanes and readback
        access(0, 1, 32'h0, 4, sel(0, 1, 0, 8'h10), "R2");
        access(0, 0, 32'h0, 4, 0, "R2");
        access(0, 1, 32'h3, 1, 32'h0000_0000, "R2");
        access(0, 1, 32'h0, 1, 32'h0000_0013, "R2");
        access(0, 0, 32'h0, 4, 0, "R2");
        access(0, 0, 32'h1, 2, 0, "R2");
        access(0, 0, 32'h2, 4, 0, "R2");

        // R3: data port with byte offset from the port
        access(1, 1, 32'h0, 4, 32'hDEAD_BEEF, "R3");
        access(1, 0, 32'h0, 4, 0, "R3");
        access(1, 0, 32'h2, 2, 0, "R3");
        access(1, 0, 32'h1, 1, 0, "R3");
        access(1, 1, 32'h3, 2, 32'h0000_5A6B, "R3");
        access(1, 0, 32'h0, 4, 0, "R3");

        // R4: truncation and zero-length
        access(1, 1, 32'h0, 8, 32'h1122_3344, "R4");
        access(1, 0, 32'h0, 8, 0, "R4");
        access(1, 0, 32'h0, 1, 0, "R4");
        access(1, 0, 32'h0, 0, 0, "R4");

        // R6: absent slot 2
        access(0, 1, 32'h0, 4, sel(0, 2, 0, 0), "R6");
        access(1, 0, 32'h0, 2, 0, "R6");
        access(1, 1, 32'h0, 4, 32'hCAFE_F00D, "R6");
        dev_present = 4'b1111;
        access(1, 0, 32'h0, 4, 0, "R6");
        dev_present = 4'b1011;

        // R5: presence conditions
        access(0, 1, 32'h0, 4, sel(1, 1, 0, 8'h10), "R5");
        access(1, 0, 32'h0, 4, 0, "R5");
        access(0, 1, 32'h0, 4, sel(0, 1, 3, 8'h10), "R5");
        access(1, 0, 32'h0, 4, 0, "R5");
        access(0, 1, 32'h0, 4, sel(0, 7, 0, 8'h10), "R5");
        access(1, 0, 32'h0, 4, 0, "R5");
        access(0, 1, 32'h0, 4, sel(0, 1, 0, 8'h10), "R5");
        access(1, 0, 32'h0, 4, 0, "R5");
        access(3, 0, 32'h0, 4, 0, "R5");
        access(2, 0, WIN + 32'h0001_0800 + 32'h10, 4, 0, "R5");

        // R7: window path, latch untouched
        access(2, 0, WIN + (32'd1 << 11) + 32'h10, 4, 0, "R7");
        access(2, 1, WIN + (32'd3 << 11) + 32'h40, 4, 32'hA5A5_0102, "R7");
        access(0, 1, 32'h0, 4, sel(0, 3, 0, 8'h40), "R7");
        access(1, 0, 32'h0, 4, 0, "R7");
        access(0, 0, 32'h0, 4, 0, "R7");

        // R8: offset wrap inside the header
        access(2, 1, WIN + (32'd3 << 11) + 32'hFE, 4, 32'h4433_2211, "R8");
        access(2, 0, WIN + (32'd3 << 11), 2, 0, "R8");
        access(2, 0, WIN + (32'd3 << 11) + 32'hFE, 4, 0, "R8");
        access(2, 0, WIN + (32'd3 << 11) + 32'hFF, 3, 0, "R8");

        repeat (2) @(negedge clk);
        check("R9", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule